// File: doc/BRIEF.md
# Cascaded Toggle PWM Generator

This block produces a pulse-width modulated output from a wide up-counter. The counter is built from several narrow timer halves joined by a ripple carry. With the default of two 8-bit halves it is a 16-bit counter with 16-bit duty resolution. On each count enable the counter advances. The enable comes from an internal prescaled tick or from an external tick, chosen by a select input. An output flip-flop toggles at two points in each period. The first is the count at which the counter reaches the active duty value. The second is the count at which the counter wraps from all-ones back to zero. On the wrap, a one-cycle interrupt pulse is also raised.

Software sets the level the flip-flop starts from, which gives either pulse polarity. The output pin drives the inverse of the flip-flop. The duty value is written one half at a time into a shadow register. The shadow is copied into the active compare register only at a wrap, or continuously while the block is stopped. This keeps a partial or mid-period write from producing a short stray pulse. While the start input is low, the counter is held at zero and the flip-flop holds the programmed initial level.

Top module: `pwm16_toggle`

## Requirements
- R1: The counter is NUM_HALVES*HALF_W bits wide, with half 0 as the least significant, and one period spans 2^(NUM_HALVES*HALF_W) count enables.
- R2: When src_ext_i is 1, only ext_tick_i advances the counter. When src_ext_i is 0, only int_tick_i advances it. The unselected tick has no effect on pwm_o or irq_o.
- R3: If a count enable moves the counter to a value equal to the active duty, the flip-flop toggles and counting continues.
- R4: A count enable that finds the counter at all-ones clears it to zero and toggles the flip-flop.
- R5: irq_o is high for exactly one clock cycle, the cycle after the edge at which the counter wraps. It is never high while the block is stopped.
- R6: While start_i is low, the counter is held at zero. The flip-flop takes init_level_i at every edge, so pwm_o equals the inverse of init_level_i one cycle later.
- R7: pwm_o is always the logical inverse of the flip-flop.
- R8: After reset the flip-flop, counter, shadow duty and active duty are all zero, so pwm_o is 1 and irq_o is 0.
- R9: duty_we_i[h] writes duty_byte_i into bits [h*HALF_W +: HALF_W] of the shadow duty. The active duty takes the shadow value present before the edge, either at a wrap or at any edge while start_i is low. A write while running takes effect only from the next period.
- R10: With an active duty of 0, the flip-flop toggles only at the wrap. With an active duty of all-ones, the flip-flop holds its toggled level for exactly one count before the wrap.
- R11: A cycle without a selected count enable leaves the counter and the flip-flop unchanged while running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Run (1) or hold stopped (0) |
| src_ext_i | input | 1 | Count source select: 1 external, 0 internal |
| int_tick_i | input | 1 | Internal prescaled count enable |
| ext_tick_i | input | 1 | External count enable |
| init_level_i | input | 1 | Initial flip-flop level loaded while stopped |
| duty_we_i | input | NUM_HALVES | Per-half write strobe for the shadow duty |
| duty_byte_i | input | HALF_W | Data for the half being written |
| pwm_o | output | 1 | PWM pin, inverse of the flip-flop |
| irq_o | output | 1 | One-cycle interrupt pulse on wrap |

## Verification
Some properties are checked on every cycle: that each half counts by exactly one on its enable, that the flip-flop holds when no toggle is due, that it loads the initial level while stopped, that the active duty moves only on a load, and that the interrupt is a single-cycle pulse seen with a cleared counter. Other behaviour only shows up in the bench's scenarios against its cycle model. This covers the exact toggle positions for a given duty, both polarities, the deferral of a mid-period duty write to the next period, the duty extremes 0 and all-ones, and counting from a sparse external tick while the other tick is ignored.

// File: rtl/pwm16_pkg.sv
package pwm16_pkg;
  typedef enum logic {
    SRC_INT = 1'b0,
    SRC_EXT = 1'b1
  } pwm_src_e;
endpackage

// File: rtl/timer_half.sv
module timer_half #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o,
  output logic         carry_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + W'(1);
  end

  assign cnt_o   = cnt_q;
  assign carry_o = inc_i && (cnt_q == '1);

  // R1: each half advances by one per enable, wrapping at its width
  assert_half_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i && !clr_i |=> cnt_o == $past(cnt_o) + W'(1));
  // R11: no enable, no change
  assert_half_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inc_i && !clr_i |=> $stable(cnt_o));
  // R6: held at zero while stopped
  assert_half_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_o == '0);
endmodule

// File: rtl/duty_buffer.sv
module duty_buffer #(
  parameter int HALF_W     = 8,
  parameter int NUM_HALVES = 2,
  localparam int CW        = HALF_W * NUM_HALVES
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_HALVES-1:0] we_i,
  input  logic [HALF_W-1:0]     data_i,
  input  logic                  load_i,
  output logic [CW-1:0]         act_o
);
  logic [CW-1:0] shadow_q;
  logic [CW-1:0] act_q;

  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_shadow
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     shadow_q[h*HALF_W +: HALF_W] <= '0;
      else if (we_i[h]) shadow_q[h*HALF_W +: HALF_W] <= data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     act_q <= '0;
    else if (load_i) act_q <= shadow_q;
  end

  assign act_o = act_q;

  // R9: active compare value moves only on a load
  assert_duty_stable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(act_o));
endmodule

// File: rtl/toggle_ff.sv
module toggle_ff (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  input  logic init_i,
  input  logic toggle_i,
  output logic ff_o
);
  logic ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ff_q <= 1'b0;
    else if (hold_i)   ff_q <= init_i;
    else if (toggle_i) ff_q <= ~ff_q;
  end

  assign ff_o = ff_q;

  // R6: stopped flip-flop follows the programmed initial level
  assert_ff_init_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> ff_o == $past(init_i));
  // R11: no toggle request, no change
  assert_ff_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hold_i && !toggle_i |=> $stable(ff_o));
  // R3: a toggle request inverts the level
  assert_ff_flip_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hold_i && toggle_i |=> ff_o != $past(ff_o));
endmodule

// File: rtl/pwm16_toggle.sv
module pwm16_toggle
  import pwm16_pkg::*;
#(
  parameter int HALF_W     = 8,
  parameter int NUM_HALVES = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic                  src_ext_i,
  input  logic                  int_tick_i,
  input  logic                  ext_tick_i,
  input  logic                  init_level_i,
  input  logic [NUM_HALVES-1:0] duty_we_i,
  input  logic [HALF_W-1:0]     duty_byte_i,
  output logic                  pwm_o,
  output logic                  irq_o
);
  localparam int CW = HALF_W * NUM_HALVES;

  pwm_src_e        src;
  logic            tick;
  logic            stopped;
  logic [NUM_HALVES:0] chain;
  logic [CW-1:0]   cnt;
  logic [CW-1:0]   cnt_next;
  logic [CW-1:0]   duty_act;
  logic            wrap;
  logic            match;
  logic            ff;
  logic            irq_q;

  assign src     = pwm_src_e'(src_ext_i);
  assign stopped = !start_i;
  assign tick    = start_i && ((src == SRC_EXT) ? ext_tick_i : int_tick_i);

  // ripple-carry cascade of narrow halves
  assign chain[0] = tick;
  for (genvar g = 0; g < NUM_HALVES; g++) begin : g_half
    timer_half #(.W(HALF_W)) u_half (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (stopped),
      .inc_i   (chain[g]),
      .cnt_o   (cnt[g*HALF_W +: HALF_W]),
      .carry_o (chain[g+1])
    );
  end

  assign wrap     = chain[NUM_HALVES];
  assign cnt_next = cnt + CW'(1);
  // duty 0 coincides with the wrap, giving a single toggle there
  assign match    = tick && (cnt_next == duty_act);

  duty_buffer #(.HALF_W(HALF_W), .NUM_HALVES(NUM_HALVES)) u_duty (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (duty_we_i),
    .data_i (duty_byte_i),
    .load_i (wrap || stopped),
    .act_o  (duty_act)
  );

  toggle_ff u_ff (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hold_i   (stopped),
    .init_i   (init_level_i),
    .toggle_i (wrap || match),
    .ff_o     (ff)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= wrap;
  end

  assign irq_o = irq_q;
  assign pwm_o = ~ff;

  // R5: interrupt is a one-cycle pulse
  assert_irq_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
  // R4: interrupt only follows a wrap to zero
  assert_irq_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> cnt == '0);
  // R5: never raised while stopped
  assert_irq_stop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !irq_o);
  // R6: stopped pin level is the inverse of the programmed level
  assert_pin_init_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> pwm_o == !$past(init_level_i));
endmodule

// File: tb/pwm16_toggle_bench.sv
`timescale 1ns/1ps
module pwm16_toggle_bench;
  localparam int HW  = 4;
  localparam int NH  = 2;
  localparam int CW  = HW * NH;
  localparam int MAX = (1 << CW) - 1;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0, src_ext_i = 1'b0, int_tick_i = 1'b0, ext_tick_i = 1'b0;
  logic          init_level_i = 1'b0;
  logic [NH-1:0] duty_we_i = '0;
  logic [HW-1:0] duty_byte_i = '0;
  logic          pwm_o, irq_o;

  pwm16_toggle #(.HALF_W(HW), .NUM_HALVES(NH)) u_pwm16_toggle (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .src_ext_i(src_ext_i),
    .int_tick_i(int_tick_i), .ext_tick_i(ext_tick_i), .init_level_i(init_level_i),
    .duty_we_i(duty_we_i), .duty_byte_i(duty_byte_i), .pwm_o(pwm_o), .irq_o(irq_o)
  );

  int checks = 0;
  int errors = 0;
  int irq_seen = 0;

  // reference state from the requirements
  int            m_cnt = 0;
  bit            m_ff = 1'b0;
  logic [CW-1:0] m_shadow = '0;
  logic [CW-1:0] m_act = '0;

  logic [1:0] exp_q[$];
  string      tag_q[$];

  task automatic step(input bit st, input bit src, input bit it, input bit et,
                      input bit init, input logic [NH-1:0] we,
                      input logic [HW-1:0] d, input string tag);
    bit            tick, irq_n;
    logic [CW-1:0] nsh;
    @(negedge clk);
    start_i = st; src_ext_i = src; int_tick_i = it; ext_tick_i = et;
    init_level_i = init; duty_we_i = we; duty_byte_i = d;
    tick  = st && (src ? et : it);
    irq_n = tick && (m_cnt == MAX);
    nsh   = m_shadow;
    for (int h = 0; h < NH; h++) if (we[h]) nsh[h*HW +: HW] = d;
    if (!st) begin
      m_cnt = 0; m_ff = init; m_act = m_shadow;
    end else if (tick) begin
      if (m_cnt == MAX) begin
        m_cnt = 0; m_ff = ~m_ff; m_act = m_shadow;
      end else begin
        m_cnt++;
        if (CW'(m_cnt) == m_act) m_ff = ~m_ff;
      end
    end
    m_shadow = nsh;
    exp_q.push_back({~m_ff, irq_n});
    tag_q.push_back(tag);
  endtask

  // monitor: pops one expectation per edge, sampled after the edge
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      logic [1:0] e;
      string      t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (irq_o) irq_seen++;
      if ({pwm_o, irq_o} !== e) begin
        errors++;
        $display("FAIL %s: pwm/irq actual=%b%b expected=%b%b at %0t",
                 t, pwm_o, irq_o, e[1], e[0], $time);
      end
    end
  end

  task automatic stop_for(input int n, input bit init, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, 1, 1, init, '0, '0, tag);
  endtask

  task automatic run_int(input int n, input bit init, input string tag);
    for (int i = 0; i < n; i++) step(1, 0, 1, i[0], init, '0, '0, tag);
  endtask

  task automatic write_duty(input logic [CW-1:0] v, input bit st, input bit init,
                            input string tag);
    step(st, 0, st, 0, init, 2'b01, v[HW-1:0], tag);
    step(st, 0, st, 0, init, 2'b10, v[CW-1:HW], tag);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R8: reset state
    checks++;
    if (pwm_o !== 1'b1 || irq_o !== 1'b0) begin
      errors++;
      $display("FAIL R8: pwm/irq actual=%b%b expected=10", pwm_o, irq_o);
    end
    // R6 R9: stopped, program duty, hold initial level 0
    stop_for(3, 0, "R6");
    write_duty(CW'(8'h40), 0, 0, "R9");
    stop_for(3, 0, "R6");
    // R1 R3 R4 R5 R7: internal source, positive polarity, two+ periods
    run_int(600, 0, "R3_R4_R5_R7");
    // R6 R7: opposite polarity
    stop_for(3, 1, "R6");
    run_int(300, 1, "R7");
    // R9: mid-period duty write deferred to next wrap
    write_duty(CW'(8'hC0), 1, 1, "R9");
    run_int(600, 1, "R9");
    // R2: external source, sparse ticks, internal tick ignored
    stop_for(2, 0, "R6");
    for (int i = 0; i < 900; i++) step(1, 1, 1, (i % 3) == 0, 0, '0, '0, "R2");
    // R2 R11: internal selected but idle, external ignored
    for (int i = 0; i < 60; i++) step(1, 0, 0, 1, 0, '0, '0, "R11");
    // R10: duty 0
    stop_for(2, 0, "R6");
    write_duty('0, 0, 0, "R10");
    stop_for(2, 0, "R10");
    run_int(600, 0, "R10");
    // R10: duty all-ones
    stop_for(2, 1, "R6");
    write_duty('1, 0, 1, "R10");
    stop_for(2, 1, "R10");
    run_int(600, 1, "R10");
    stop_for(4, 0, "R5");
    repeat (3) @(negedge clk);
    // R1 R5: the wrap pulse was actually observed
    checks++;
    if (irq_seen < 8) begin
      errors++;
      $display("FAIL R1: irq pulses actual=%0d expected>=8", irq_seen);
    end
    summary();
    $finish;
  end
endmodule